// File: doc/BRIEF.md
# Single Store Bus Cycle Sequencer

This block drives the memory bus for a store of one register in a pipelined processor core. A one-cycle start strobe hands it the current program counter, the effective address already worked out by the ALU, the value to store, the access size, the current privilege (translation) value and a flag that forces the data access to be translated as a user access. The block captures these operands when the strobe is accepted. It then runs exactly two bus cycles and returns to idle.

The first bus cycle is an instruction prefetch that reads from the program counter plus two instruction lengths. The second bus cycle writes the stored value to the effective address. In that same cycle the block pulses a base-writeback enable, so the register file can update the base register in parallel with the write, and it pulses done. When the block is idle again it presents the program counter plus three instruction lengths as the next address. All outputs are registered. The ALU, the register file and the memory sit outside the block.

Top module: `store_seq`

## Requirements
- R1: After reset, mreq_n_o is 1, wr_o is 0, addr_o is 0, base_we_o is 0 and done_o is 0.
- R2: A start_i accepted while idle makes the next cycle the fetch cycle: addr_o = pc_i + 2*IL_BYTES, size_o is the instruction size (10 for IL_BYTES = 4, 01 for IL_BYTES = 2), wr_o = 0, mreq_n_o = 0, seq_o = 0, opc_n_o = 0, wdata_o = 0 and trans_o equals mode_i.
- R3: The cycle after the fetch cycle is the data cycle: addr_o = ea_i, size_o = size_i (00 byte, 01 halfword, 10 word), wr_o = 1, wdata_o = wdata_i, mreq_n_o = 0, seq_o = 0 and opc_n_o = 1.
- R4: base_we_o is 1 in the data cycle and 0 in every other cycle.
- R5: trans_o in the data cycle is 0 when force_user_i was 1 at the start, and mode_i otherwise.
- R6: The cycle after the data cycle is idle: mreq_n_o = 1, wr_o = 0, wdata_o = 0, and addr_o = pc_i + 3*IL_BYTES, held until the next start.
- R7: done_o is a one-cycle pulse, high in the data cycle only.
- R8: start_i is ignored during the fetch and data cycles: no extra bus cycle follows the data cycle.
- R9: All operands are sampled in the cycle start_i is accepted; later changes of pc_i, ea_i, wdata_i, size_i, mode_i or force_user_i do not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start strobe for one store |
| pc_i | input | AW | Current program counter |
| ea_i | input | AW | Effective address from the ALU |
| wdata_i | input | DW | Value to be stored |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| mode_i | input | 1 | Current translation (privilege) value |
| force_user_i | input | 1 | Force user translation on the data cycle |
| addr_o | output | AW | Bus address |
| size_o | output | 2 | Bus access size |
| wr_o | output | 1 | 1 = write, 0 = read |
| wdata_o | output | DW | Write data |
| mreq_n_o | output | 1 | Memory request, active low |
| seq_o | output | 1 | Sequential access indicator |
| opc_n_o | output | 1 | 0 = opcode fetch, 1 = data access |
| trans_o | output | 1 | Translation (privilege) output |
| base_we_o | output | 1 | Base register writeback enable |
| done_o | output | 1 | Store finished |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives while a store is already in progress, combined with operand inputs that change under it. If the block re-armed on that strobe or sampled operands late, it would give a third bus cycle or corrupted data-cycle values. The bench holds start_i high through the fetch and data cycles on alternate operations and scrambles every operand input right after the accepting edge. It then checks that the data and idle cycles still carry the captured values and that idle persists one cycle further. A sweep over every size, mode and force combination, including a program counter that wraps past the top of the address space, covers the rest.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } size_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_FETCH = 2'b01,
        PH_DATA  = 2'b10
    } phase_e;
endpackage

// File: rtl/store_seq_pcoff.sv
module store_seq_pcoff #(
    parameter int AW       = 32,
    parameter int IL_BYTES = 4,
    parameter int MULT     = 2
) (
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] pc_off
);
    localparam logic [AW-1:0] OFFSET = AW'(MULT * IL_BYTES);

    assign pc_off = pc + OFFSET;
endmodule

// File: rtl/store_seq_isize.sv
module store_seq_isize #(
    parameter int IL_BYTES = 4
) (
    output store_seq_pkg::size_e isz
);
    generate
        if (IL_BYTES == 2) begin : g_half
            assign isz = store_seq_pkg::SZ_HALF;
        end else begin : g_word
            assign isz = store_seq_pkg::SZ_WORD;
        end
    endgenerate
endmodule

// File: rtl/store_seq_xlat.sv
module store_seq_xlat (
    input  logic mode,
    input  logic force_user,
    output logic trans
);
    assign trans = force_user ? 1'b0 : mode;
endmodule

// File: rtl/store_seq.sv
module store_seq #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int IL_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] ea_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [1:0]    size_i,
    input  logic          mode_i,
    input  logic          force_user_i,
    output logic [AW-1:0] addr_o,
    output logic [1:0]    size_o,
    output logic          wr_o,
    output logic [DW-1:0] wdata_o,
    output logic          mreq_n_o,
    output logic          seq_o,
    output logic          opc_n_o,
    output logic          trans_o,
    output logic          base_we_o,
    output logic          done_o
);
    import store_seq_pkg::*;

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] pc;
        logic [AW-1:0] ea;
        logic [DW-1:0] wd;
        size_e         sz;
        logic          mode;
        logic          fu;
        logic [AW-1:0] addr;
        size_e         osz;
        logic          wr;
        logic [DW-1:0] wdo;
        logic          mreq_n;
        logic          opc_n;
        logic          trans;
        logic          bwe;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0] pc_fetch;
    logic [AW-1:0] pc_next;
    size_e         isz;
    logic          trans_data;

    store_seq_pcoff #(.AW(AW), .IL_BYTES(IL_BYTES), .MULT(2)) u_off2 (
        .pc     (pc_i),
        .pc_off (pc_fetch)
    );

    store_seq_pcoff #(.AW(AW), .IL_BYTES(IL_BYTES), .MULT(3)) u_off3 (
        .pc     (st_q.pc),
        .pc_off (pc_next)
    );

    store_seq_isize #(.IL_BYTES(IL_BYTES)) u_isz (
        .isz (isz)
    );

    store_seq_xlat u_xlat (
        .mode       (st_q.mode),
        .force_user (st_q.fu),
        .trans      (trans_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bwe  = 1'b0;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase  = PH_FETCH;
                    st_d.pc     = pc_i;
                    st_d.ea     = ea_i;
                    st_d.wd     = wdata_i;
                    st_d.sz     = size_e'(size_i);
                    st_d.mode   = mode_i;
                    st_d.fu     = force_user_i;
                    st_d.addr   = pc_fetch;
                    st_d.osz    = isz;
                    st_d.wr     = 1'b0;
                    st_d.wdo    = '0;
                    st_d.mreq_n = 1'b0;
                    st_d.opc_n  = 1'b0;
                    st_d.trans  = mode_i;
                end
            end
            PH_FETCH: begin
                st_d.phase  = PH_DATA;
                st_d.addr   = st_q.ea;
                st_d.osz    = st_q.sz;
                st_d.wr     = 1'b1;
                st_d.wdo    = st_q.wd;
                st_d.mreq_n = 1'b0;
                st_d.opc_n  = 1'b1;
                st_d.trans  = trans_data;
                st_d.bwe    = 1'b1;
                st_d.done   = 1'b1;
            end
            PH_DATA: begin
                st_d.phase  = PH_IDLE;
                st_d.addr   = pc_next;
                st_d.osz    = isz;
                st_d.wr     = 1'b0;
                st_d.wdo    = '0;
                st_d.mreq_n = 1'b1;
                st_d.opc_n  = 1'b0;
                st_d.trans  = st_q.mode;
            end
            default: begin
                st_d.phase  = PH_IDLE;
                st_d.mreq_n = 1'b1;
                st_d.wr     = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.phase  <= PH_IDLE;
            st_q.sz     <= SZ_BYTE;
            st_q.osz    <= isz;
            st_q.mreq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = st_q.addr;
    assign size_o    = st_q.osz;
    assign wr_o      = st_q.wr;
    assign wdata_o   = st_q.wdo;
    assign mreq_n_o  = st_q.mreq_n;
    assign seq_o     = 1'b0;
    assign opc_n_o   = st_q.opc_n;
    assign trans_o   = st_q.trans;
    assign base_we_o = st_q.bwe;
    assign done_o    = st_q.done;
endmodule

// File: rtl/store_seq_chk.sv
module store_seq_chk #(
    parameter int AW       = 32,
    parameter int IL_BYTES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [AW-1:0] pc_i,
    input logic          mode_i,
    input logic [AW-1:0] addr_o,
    input logic          wr_o,
    input logic          mreq_n_o,
    input logic          seq_o,
    input logic          opc_n_o,
    input logic          trans_o,
    input logic          base_we_o,
    input logic          done_o
);
    logic fetch_c, data_c;
    assign fetch_c = !mreq_n_o && !opc_n_o;
    assign data_c  = !mreq_n_o && opc_n_o;

    AST_FETCH_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_c |-> ($past(start_i) && !wr_o && trans_o == $past(mode_i)
                     && addr_o == AW'($past(pc_i) + AW'(2 * IL_BYTES)))); // R2
    AST_FETCH_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_c |=> (data_c && wr_o)); // R3
    AST_WB_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        base_we_o |-> (data_c && wr_o)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> base_we_o); // R7
    AST_NO_THIRD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_c |=> (mreq_n_o && !wr_o)); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_c || data_c) |=> !fetch_c); // R8
    AST_SEQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mreq_n_o |-> !seq_o); // R3
endmodule

bind store_seq store_seq_chk #(.AW(AW), .IL_BYTES(IL_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pc_i      (pc_i),
    .mode_i    (mode_i),
    .addr_o    (addr_o),
    .wr_o      (wr_o),
    .mreq_n_o  (mreq_n_o),
    .seq_o     (seq_o),
    .opc_n_o   (opc_n_o),
    .trans_o   (trans_o),
    .base_we_o (base_we_o),
    .done_o    (done_o)
);

// File: tb/sim_store_seq.sv
`timescale 1ns/1ps
module sim_store_seq;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic [AW-1:0] ea_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [1:0]    size_i = '0;
    logic          mode_i = 1'b0;
    logic          force_user_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic [1:0]    size_o;
    logic          wr_o;
    logic [DW-1:0] wdata_o;
    logic          mreq_n_o, seq_o, opc_n_o, trans_o, base_we_o, done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    store_seq #(.AW(AW), .DW(DW), .IL_BYTES(IL)) u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [AW-1:0] pc, input logic [AW-1:0] ea,
                          input logic [DW-1:0] wd, input logic [1:0] sz,
                          input logic md, input logic fu, input bit busy);
        @(negedge clk);
        start_i = 1'b1; pc_i = pc; ea_i = ea; wdata_i = wd;
        size_i = sz; mode_i = md; force_user_i = fu;
        @(negedge clk);
        // fetch cycle; scramble inputs (R9) and maybe keep start high (R8)
        start_i = busy; pc_i = ~pc; ea_i = ~ea; wdata_i = ~wd;
        size_i = 2'(sz + 1); mode_i = ~md; force_user_i = ~fu;
        chk("R2 addr", 64'(addr_o), 64'(AW'(pc + AW'(2 * IL))));
        chk("R2 size", 64'(size_o), 64'(2'b10));
        chk("R2 wr", 64'(wr_o), 64'(1'b0));
        chk("R2 mreq_n", 64'(mreq_n_o), 64'(1'b0));
        chk("R2 seq", 64'(seq_o), 64'(1'b0));
        chk("R2 opc_n", 64'(opc_n_o), 64'(1'b0));
        chk("R2 trans", 64'(trans_o), 64'(md));
        chk("R2 wdata", 64'(wdata_o), 64'(0));
        chk("R4 bwe fetch", 64'(base_we_o), 64'(1'b0));
        chk("R7 done fetch", 64'(done_o), 64'(1'b0));
        @(negedge clk);
        chk("R3 R9 addr", 64'(addr_o), 64'(ea));
        chk("R3 R9 size", 64'(size_o), 64'(sz));
        chk("R3 wr", 64'(wr_o), 64'(1'b1));
        chk("R3 R9 wdata", 64'(wdata_o), 64'(wd));
        chk("R3 mreq_n", 64'(mreq_n_o), 64'(1'b0));
        chk("R3 seq", 64'(seq_o), 64'(1'b0));
        chk("R3 opc_n", 64'(opc_n_o), 64'(1'b1));
        chk("R5 trans", 64'(trans_o), 64'(fu ? 1'b0 : md));
        chk("R4 bwe data", 64'(base_we_o), 64'(1'b1));
        chk("R7 done data", 64'(done_o), 64'(1'b1));
        @(negedge clk);
        start_i = 1'b0;
        chk("R6 R8 mreq_n", 64'(mreq_n_o), 64'(1'b1));
        chk("R6 wr", 64'(wr_o), 64'(1'b0));
        chk("R6 wdata", 64'(wdata_o), 64'(0));
        chk("R6 R9 addr", 64'(addr_o), 64'(AW'(pc + AW'(3 * IL))));
        chk("R4 bwe idle", 64'(base_we_o), 64'(1'b0));
        chk("R7 done idle", 64'(done_o), 64'(1'b0));
        if (busy) begin
            @(negedge clk);
            chk("R8 still idle", 64'(mreq_n_o), 64'(1'b1));
            chk("R8 R6 addr held", 64'(addr_o), 64'(AW'(pc + AW'(3 * IL))));
            chk("R8 no done", 64'(done_o), 64'(1'b0));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mreq_n", 64'(mreq_n_o), 64'(1'b1));
        chk("R1 wr", 64'(wr_o), 64'(1'b0));
        chk("R1 addr", 64'(addr_o), 64'(0));
        chk("R1 bwe", 64'(base_we_o), 64'(1'b0));
        chk("R1 done", 64'(done_o), 64'(1'b0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 64'(mreq_n_o), 64'(1'b1));
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 3; s++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int f = 0; f < 2; f++) begin
                        logic [AW-1:0] pc;
                        logic [AW-1:0] ea;
                        logic [DW-1:0] wd;
                        case (p)
                            0: pc = 32'h0000_0000;
                            1: pc = 32'h0000_1000;
                            2: pc = 32'h7FFF_FFFC;
                            default: pc = 32'hFFFF_FFF8;
                        endcase
                        ea = (pc ^ 32'h1234_5670) + AW'(s);
                        wd = {pc[15:0], 8'(s), 4'(m), 4'(f)} ^ 32'hA5A5_0000;
                        run_op(pc, ea, wd, 2'(s), m[0], f[0], ((p + s + m + f) % 2) == 1);
                    end
                end
            end
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule